// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo serial audio stream as a slave and turns it into parallel sample words. The bit clock, the channel-select (word) clock and the serial data line all come from outside. They are synchronised into a faster system clock, and the bit-clock rising edges are found there. Five framings can be chosen at run time through a 3-bit format input: three right-aligned (LSB-justified) word widths, a left-aligned 24-bit framing, and an I2S-style 24-bit framing. Narrower words are sign-extended. One strobe per stereo frame delivers the left and right words together.

A long-run zero watcher sits beside the receiver. For each channel it raises a flag once that channel's samples have been exactly zero for a parameterised number of consecutive frames (8192 by default), and it drops the flag on the next nonzero sample. The two flags can also be tied together so that they rise only when both channels are silent. They can be disabled, which holds them at the inactive level, and their polarity can be inverted. A separate core-reset input clears the receiver and forces both flags active. The flags stay active until two frames have been received after that reset is released.

Top module: `audio_serial_rx`

## Requirements
- R1: Serial data is MSB first and two's complement, sampled on the bit-clock rising edge. For every stereo frame, `frame_valid` pulses for one system clock with `left_word` and `right_word` both valid. The pulse comes only after a left word and then a right word have been received.
- R2: Format code 2 selects a 24-bit left-aligned framing. The MSB is on the first bit-clock rise after the word clock changes, and word clock high marks the left channel. At least 24 bit clocks per half-frame are needed.
- R3: Format code 3 selects a 24-bit I2S-style framing. The MSB is on the second bit-clock rise after the word clock changes, and word clock low marks the left channel. This works with exactly 24 bit clocks per half-frame, where the LSB falls on the first bit of the following half.
- R4: Format codes 0, 1 and 4 select right-aligned framings with 16, 20 and 24 bits. The last bit before each word-clock change is the sample LSB, and earlier bits in the half are ignored. Word clock high marks the left channel. The word is sign-extended to the output width. The minimum is 16, 20 and 24 bit clocks per half-frame respectively.
- R5: Format codes 5, 6 and 7 behave exactly like code 2, which is the default framing.
- R6: With detection on in separate mode, a channel's flag becomes active after the frame that completes `ZERO_FRAMES` consecutive all-zero samples on that channel, and not one frame earlier. It returns to inactive after the first nonzero sample.
- R7: In combined mode both flags are active only when both channels have each completed the zero run, and they always agree.
- R8: With `zd_enable` low, both flags sit at the inactive level. `zd_invert` high inverts both flags, so the active level becomes 0 and the inactive level becomes 1.
- R9: While `core_rst` is high, both flags are active whether detection is enabled or not. After release they remain active until two frames have been delivered.
- R10: After system reset `frame_valid` is 0, both words are 0, and both flags are at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| core_rst | input | 1 | Synchronous core reset: clears the receiver and forces the flags active |
| bclk_in | input | 1 | External serial bit clock |
| lrclk_in | input | 1 | External word (channel-select) clock |
| sdata_in | input | 1 | External serial data |
| fmt_sel | input | 3 | Framing code (0..4; 5..7 alias to 2) |
| zd_enable | input | 1 | Zero detection enable |
| zd_combine | input | 1 | 1: flags rise only when both channels are silent |
| zd_invert | input | 1 | 1: flags are active low |
| left_word | output | DATA_W | Left sample, sign-extended |
| right_word | output | DATA_W | Right sample, sign-extended |
| frame_valid | output | 1 | One-cycle strobe, both words valid |
| zflag_left | output | 1 | Left-channel zero flag |
| zflag_right | output | 1 | Right-channel zero flag |

## Verification
The hardest situation to reach from the ports is the I2S-style framing at its minimum 24 bit clocks per half-frame. There, each sample's LSB rides on the first bit of the opposite channel's half. The bench produces it by carrying the previous word's LSB into bit zero of every half. The zero-run threshold is the other hard case, because its default needs thousands of frames. The bench therefore shortens it by parameter and walks the count to one frame short and then exactly to the threshold, in separate mode, combined mode and during the release window after a core reset.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

   localparam int unsigned SAMPLE_W = 24;

   typedef enum logic [1:0] {
      ALIGN_LSB = 2'd0,
      ALIGN_MSB = 2'd1,
      ALIGN_I2S = 2'd2
   } align_e;

   typedef struct packed {
      align_e     align;
      logic [4:0] width;
   } frame_cfg_t;

   function automatic frame_cfg_t decode_format(input logic [2:0] code);
      frame_cfg_t c;
      case (code)
         3'd0:    begin c.align = ALIGN_LSB; c.width = 5'd16; end
         3'd1:    begin c.align = ALIGN_LSB; c.width = 5'd20; end
         3'd3:    begin c.align = ALIGN_I2S; c.width = 5'd24; end
         3'd4:    begin c.align = ALIGN_LSB; c.width = 5'd24; end
         default: begin c.align = ALIGN_MSB; c.width = 5'd24; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/rx_pin_sync.sv
module rx_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_in,
   input  logic lrclk_in,
   input  logic sdata_in,
   output logic bit_rise,
   output logic lr_level,
   output logic sd_level
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rx_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][2:0] pipe;
   logic                   bclk_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe      <= '0;
         bclk_last <= 1'b0;
      end else begin
         pipe      <= {pipe[STAGES-2:0], {bclk_in, lrclk_in, sdata_in}};
         bclk_last <= pipe[LAST][2];
      end
   end

   assign bit_rise = pipe[LAST][2] & ~bclk_last;
   assign lr_level = pipe[LAST][1];
   assign sd_level = pipe[LAST][0];

endmodule

// File: rtl/rx_frame_deser.sv
module rx_frame_deser
   import audio_rx_pkg::*;
#(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              bit_rise,
   input  logic              lr_level,
   input  logic              sd_level,
   input  frame_cfg_t        cfg,
   output logic [DATA_W-1:0] left_word,
   output logic [DATA_W-1:0] right_word,
   output logic              frame_valid
);

   localparam logic [IDX_W-1:0] IDX_MAX  = '1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SAMPLE_W - 1);

   logic [1:0]                armed;
   logic                      lr_dly;
   logic                      lr_prev;
   logic                      synced;
   logic                      have_left;
   logic [IDX_W-1:0]          idx;
   logic [IDX_W-1:0]          idx_nxt;
   logic [SAMPLE_W-1:0]       shreg;
   logic [DATA_W-1:0]         left_hold;
   logic                      is_i2s;
   logic                      lr_eff;
   logic                      boundary;
   logic                      cap_msb;
   logic                      cap_lsb;
   logic                      cap_level;
   logic                      cap_left;
   logic signed [SAMPLE_W-1:0] ext_w;
   logic [DATA_W-1:0]         cap_word;

   // I2S-style framing is handled as left-aligned framing against a word
   // clock delayed by one bit, which moves the MSB onto index zero.
   always_comb begin
      is_i2s    = (cfg.align == ALIGN_I2S);
      lr_eff    = is_i2s ? lr_dly : lr_level;
      boundary  = (armed == 2'd2) && (lr_eff != lr_prev);
      idx_nxt   = boundary ? '0 : ((idx == IDX_MAX) ? idx : idx + 1'b1);
      cap_msb   = bit_rise && synced && !boundary &&
                  (cfg.align != ALIGN_LSB) && (idx_nxt == IDX_LAST);
      cap_lsb   = bit_rise && synced && boundary && (cfg.align == ALIGN_LSB);
      cap_level = cap_lsb ? lr_prev : lr_eff;
      cap_left  = is_i2s ? ~cap_level : cap_level;
      if (cap_lsb) begin
         case (cfg.width)
            5'd16:   ext_w = {{8{shreg[15]}}, shreg[15:0]};
            5'd20:   ext_w = {{4{shreg[19]}}, shreg[19:0]};
            default: ext_w = shreg;
         endcase
      end else begin
         ext_w = {shreg[SAMPLE_W-2:0], sd_level};
      end
      cap_word = DATA_W'(ext_w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed       <= '0;
         lr_dly      <= 1'b0;
         lr_prev     <= 1'b0;
         synced      <= 1'b0;
         have_left   <= 1'b0;
         idx         <= '0;
         shreg       <= '0;
         left_hold   <= '0;
         left_word   <= '0;
         right_word  <= '0;
         frame_valid <= 1'b0;
      end else begin
         frame_valid <= 1'b0;
         if (clr) begin
            armed     <= '0;
            lr_dly    <= 1'b0;
            lr_prev   <= 1'b0;
            synced    <= 1'b0;
            have_left <= 1'b0;
            idx       <= '0;
            shreg     <= '0;
         end else if (bit_rise) begin
            lr_dly  <= lr_level;
            lr_prev <= lr_eff;
            if (armed != 2'd2) armed <= armed + 2'd1;
            idx     <= idx_nxt;
            shreg   <= {shreg[SAMPLE_W-2:0], sd_level};
            if (boundary) synced <= 1'b1;
            if (cap_msb || cap_lsb) begin
               if (cap_left) begin
                  left_hold <= cap_word;
                  have_left <= 1'b1;
               end else if (have_left) begin
                  left_word   <= left_hold;
                  right_word  <= cap_word;
                  frame_valid <= 1'b1;
                  have_left   <= 1'b0;
               end
            end
         end
      end
   end

   assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

endmodule

// File: rtl/rx_zero_watch.sv
module rx_zero_watch #(
   parameter int unsigned DATA_W         = 24,
   parameter int unsigned ZERO_FRAMES    = 8192,
   parameter int unsigned RELEASE_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_rst,
   input  logic              frame_valid,
   input  logic [DATA_W-1:0] left_word,
   input  logic [DATA_W-1:0] right_word,
   input  logic              det_enable,
   input  logic              det_combine,
   output logic [1:0]        flag_raw
);

   localparam int unsigned RUN_W  = $clog2(ZERO_FRAMES + 1);
   localparam int unsigned HOLD_W = $clog2(RELEASE_FRAMES + 1);
   localparam logic [RUN_W-1:0]  RUN_TOP  = RUN_W'(ZERO_FRAMES);
   localparam logic [HOLD_W-1:0] HOLD_TOP = HOLD_W'(RELEASE_FRAMES);

   logic [1:0][DATA_W-1:0] words;
   logic [1:0]             run_done;
   logic [HOLD_W-1:0]      hold_q;
   logic                   hold_force;
   logic [1:0]             flag_nxt;

   assign words = {right_word, left_word};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         hold_q <= '0;
      else if (core_rst)                  hold_q <= HOLD_TOP;
      else if (frame_valid && hold_q != 0) hold_q <= hold_q - 1'b1;
   end

   assign hold_force = core_rst || (hold_q != '0);

   genvar ch;
   generate
      for (ch = 0; ch < 2; ch++) begin : g_chan
         logic [RUN_W-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        run_q <= '0;
            else if (core_rst) run_q <= '0;
            else if (frame_valid) begin
               if (words[ch] == '0) run_q <= (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
               else                 run_q <= '0;
            end
         end
         assign run_done[ch] = (run_q == RUN_TOP);

         assert_zero_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_valid && (words[ch] != '0)) ##1 (!core_rst && (hold_q == '0))
               |=> !flag_raw[ch]);
      end
   endgenerate

   always_comb begin
      if (hold_force)       flag_nxt = 2'b11;
      else if (!det_enable) flag_nxt = 2'b00;
      else if (det_combine) flag_nxt = {2{&run_done}};
      else                  flag_nxt = run_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_raw <= 2'b00;
      else        flag_raw <= flag_nxt;
   end

   assert_combined_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (det_enable && det_combine && !hold_force) |=> (flag_raw[0] == flag_raw[1]));

   assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_enable && !hold_force) |=> (flag_raw == 2'b00));

   assert_core_reset_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |=> (flag_raw == 2'b11));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
   import audio_rx_pkg::*;
#(
   parameter int unsigned DATA_W         = 24,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned IDX_W          = 7,
   parameter int unsigned ZERO_FRAMES    = 8192,
   parameter int unsigned RELEASE_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_rst,
   input  logic              bclk_in,
   input  logic              lrclk_in,
   input  logic              sdata_in,
   input  logic [2:0]        fmt_sel,
   input  logic              zd_enable,
   input  logic              zd_combine,
   input  logic              zd_invert,
   output logic [DATA_W-1:0] left_word,
   output logic [DATA_W-1:0] right_word,
   output logic              frame_valid,
   output logic              zflag_left,
   output logic              zflag_right
);

   generate
      if (DATA_W < SAMPLE_W) begin : g_bad_width
         $error("audio_serial_rx: DATA_W must hold a full sample");
      end
      if ((2 ** IDX_W) <= SAMPLE_W) begin : g_bad_index
         $error("audio_serial_rx: IDX_W too narrow for a half-frame");
      end
      if (ZERO_FRAMES < 1 || RELEASE_FRAMES < 1) begin : g_bad_counts
         $error("audio_serial_rx: frame counts must be positive");
      end
   endgenerate

   frame_cfg_t cfg;
   logic       bit_rise;
   logic       lr_level;
   logic       sd_level;
   logic [1:0] flag_raw;

   assign cfg = decode_format(fmt_sel);

   rx_pin_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_in  (bclk_in),
      .lrclk_in (lrclk_in),
      .sdata_in (sdata_in),
      .bit_rise (bit_rise),
      .lr_level (lr_level),
      .sd_level (sd_level)
   );

   rx_frame_deser #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) i_deser (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (core_rst),
      .bit_rise    (bit_rise),
      .lr_level    (lr_level),
      .sd_level    (sd_level),
      .cfg         (cfg),
      .left_word   (left_word),
      .right_word  (right_word),
      .frame_valid (frame_valid)
   );

   rx_zero_watch #(
      .DATA_W         (DATA_W),
      .ZERO_FRAMES    (ZERO_FRAMES),
      .RELEASE_FRAMES (RELEASE_FRAMES)
   ) i_zero (
      .clk         (clk),
      .rst_n       (rst_n),
      .core_rst    (core_rst),
      .frame_valid (frame_valid),
      .left_word   (left_word),
      .right_word  (right_word),
      .det_enable  (zd_enable),
      .det_combine (zd_combine),
      .flag_raw    (flag_raw)
   );

   assign zflag_left  = flag_raw[0] ^ zd_invert;
   assign zflag_right = flag_raw[1] ^ zd_invert;

endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_CLKS  = 4;
   localparam int ZERO_RUN   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_rst = 1'b0;
   logic        bclk = 1'b0;
   logic        lrclk = 1'b0;
   logic        sdata = 1'b0;
   logic [2:0]  fmt = 3'd2;
   logic        zd_enable = 1'b0;
   logic        zd_combine = 1'b0;
   logic        zd_invert = 1'b0;
   logic [23:0] left_word;
   logic [23:0] right_word;
   logic        frame_valid;
   logic        zflag_left;
   logic        zflag_right;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   int   cur_mode = 2;
   logic plsb = 1'b0;
   logic [47:0] exp_q[$];
   int          tag_q[$];

   audio_serial_rx #(
      .ZERO_FRAMES (ZERO_RUN)
   ) i_audio_serial_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .core_rst    (core_rst),
      .bclk_in     (bclk),
      .lrclk_in    (lrclk),
      .sdata_in    (sdata),
      .fmt_sel     (fmt),
      .zd_enable   (zd_enable),
      .zd_combine  (zd_combine),
      .zd_invert   (zd_invert),
      .left_word   (left_word),
      .right_word  (right_word),
      .frame_valid (frame_valid),
      .zflag_left  (zflag_left),
      .zflag_right (zflag_right)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic string req_of(input int m);
      case (m)
         0, 1, 4: return "R4";
         3:       return "R3";
         2:       return "R2";
         default: return "R5";
      endcase
   endfunction

   function automatic int width_of(input int m);
      case (m)
         0:       return 16;
         1:       return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [23:0] sext(input int m, input logic [23:0] w);
      case (m)
         0:       return {{8{w[15]}}, w[15:0]};
         1:       return {{4{w[19]}}, w[19:0]};
         default: return w;
      endcase
   endfunction

   // bit k of a half-frame of h bits carrying word w
   function automatic logic half_bit(input int m, input int h, input int k, input logic [23:0] w,
                                     input logic prev_lsb);
      int n;
      logic junk;
      junk = 1'($urandom & 1);
      if (m == 3) begin
         if (k == 0)  return prev_lsb;
         if (k <= 24) return w[24-k];
         return junk;
      end
      if (m == 0 || m == 1 || m == 4) begin
         n = width_of(m);
         return (k >= h - n) ? w[h-1-k] : junk;
      end
      return (k < 24) ? w[23-k] : junk;
   endfunction

   always @(negedge clk) begin
      if (frame_valid && exp_q.size() > 0) begin
         logic [47:0] e;
         int          m;
         e = exp_q.pop_front();
         m = tag_q.pop_front();
         check(left_word == e[47:24], {req_of(m), " R1 left"}, {24'd0, left_word}, {24'd0, e[47:24]});
         check(right_word == e[23:0], {req_of(m), " R1 right"}, {24'd0, right_word}, {24'd0, e[23:0]});
      end
   end

   task automatic drive_bit(input logic lr, input logic d);
      bclk  = 1'b0;
      lrclk = lr;
      sdata = d;
      repeat (HALF_CLKS) @(negedge clk);
      bclk = 1'b1;
      repeat (HALF_CLKS) @(negedge clk);
   endtask

   task automatic send_half(input logic lvl, input logic [23:0] w, input int h);
      for (int k = 0; k < h; k++) drive_bit(lvl, half_bit(cur_mode, h, k, w, plsb));
      plsb = w[0];
   endtask

   task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input int h);
      logic left_lvl;
      left_lvl = (cur_mode == 3) ? 1'b0 : 1'b1;
      send_half(left_lvl, l, h);
      send_half(~left_lvl, r, h);
   endtask

   task automatic start_segment(input int m);
      logic idle_lvl;
      idle_lvl = (m == 3) ? 1'b1 : 1'b0;
      @(negedge clk);
      core_rst = 1'b1;
      fmt      = 3'(m);
      cur_mode = m;
      exp_q.delete();
      tag_q.delete();
      plsb  = 1'b0;
      bclk  = 1'b0;
      lrclk = idle_lvl;
      repeat (4) @(negedge clk);
      core_rst = 1'b0;
      for (int i = 0; i < 4; i++) drive_bit(idle_lvl, 1'b0);
   endtask

   task automatic run_segment(input int m, input int h, input int nf);
      int          n;
      logic [23:0] mask;
      logic [23:0] l;
      logic [23:0] r;
      n    = width_of(m);
      mask = 24'((64'd1 << n) - 1);
      start_segment(m);
      for (int i = 0; i < nf; i++) begin
         if (i == 0) begin
            l = 24'((64'd1 << (n - 1)) - 1);
            r = 24'(64'd1 << (n - 1));
         end else if (i == 1) begin
            l = mask;
            r = 24'd0;
         end else begin
            l = 24'($urandom) & mask;
            r = 24'($urandom) & mask;
         end
         exp_q.push_back({sext(m, l), sext(m, r)});
         tag_q.push_back(m);
         send_frame(l, r, h);
      end
      send_frame(24'd0, 24'd0, h);
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, {req_of(m), " R1 frames delivered"}, 48'(exp_q.size()), 48'd0);
   endtask

   function automatic logic [23:0] nz_word();
      return 24'($urandom) | 24'd1;
   endfunction

   task automatic check_flags(input logic [1:0] exp, input string req);
      check({zflag_right, zflag_left} == exp, req, {46'd0, zflag_right, zflag_left}, {46'd0, exp});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0A11));
      zd_invert = 1'b1;
      repeat (5) @(negedge clk);
      // R10: reset state; with inversion on, the inactive level is 1
      check(frame_valid == 1'b0, "R10 strobe", 48'(frame_valid), 48'd0);
      check(left_word == 24'd0, "R10 left", 48'(left_word), 48'd0);
      check(right_word == 24'd0, "R10 right", 48'(right_word), 48'd0);
      check_flags(2'b11, "R10 R8 inverted idle flags");
      zd_invert = 1'b0;
      @(negedge clk);
      check_flags(2'b00, "R10 idle flags");
      rst_n = 1'b1;

      run_segment(0, 16, 6);
      run_segment(0, 32, 6);
      run_segment(1, 20, 6);
      run_segment(1, 32, 6);
      run_segment(2, 24, 6);
      run_segment(2, 32, 6);
      run_segment(3, 24, 6);
      run_segment(3, 32, 6);
      run_segment(4, 24, 6);
      run_segment(4, 32, 6);
      run_segment(5, 32, 6);
      run_segment(6, 32, 6);
      run_segment(7, 24, 6);

      // zero watcher, left-aligned framing, 32 bits per half
      zd_enable  = 1'b1;
      zd_combine = 1'b0;
      start_segment(2);
      check_flags(2'b11, "R9 active after core reset");
      send_frame(nz_word(), nz_word(), 32);
      check_flags(2'b11, "R9 still held after one frame");
      send_frame(nz_word(), nz_word(), 32);
      check_flags(2'b00, "R9 released after two frames");
      for (int i = 1; i <= ZERO_RUN; i++) begin
         send_frame(24'd0, nz_word(), 32);
         if (i == ZERO_RUN - 1) check_flags(2'b00, "R6 one frame short");
      end
      check_flags(2'b01, "R6 left run complete");
      send_frame(nz_word(), nz_word(), 32);
      check_flags(2'b00, "R6 drop on nonzero");

      zd_combine = 1'b1;
      for (int i = 1; i <= ZERO_RUN; i++) begin
         send_frame(24'd0, 24'd0, 32);
         if (i == ZERO_RUN - 1) check_flags(2'b00, "R7 combined one short");
      end
      check_flags(2'b11, "R7 combined both silent");
      send_frame(24'd0, nz_word(), 32);
      check_flags(2'b00, "R7 combined right breaks");
      zd_combine = 1'b0;
      repeat (3) @(negedge clk);
      check_flags(2'b01, "R7 R6 separate after combined");
      zd_invert = 1'b1;
      repeat (3) @(negedge clk);
      check_flags(2'b10, "R8 inverted polarity");
      zd_enable = 1'b0;
      repeat (3) @(negedge clk);
      check_flags(2'b11, "R8 disabled inverted idle");
      zd_invert = 1'b0;
      repeat (3) @(negedge clk);
      check_flags(2'b00, "R8 disabled idle");
      core_rst = 1'b1;
      repeat (3) @(negedge clk);
      check_flags(2'b11, "R9 forced while disabled");
      core_rst = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule